// File: doc/BRIEF.md
# Interleaved MSI Vector Collector

This block collects message-signalled interrupts for a host bridge. Each inbound interrupt message is a write of a vector number to one doorbell register. The block records the vector as a pending bit. It holds 32 vectors in 8 groups of 4 bits, and drives one interrupt line per group. The layout is interleaved: vector `v` lands in group `v mod 8`, bit `v div 8`. Group 0 therefore collects vectors 0, 8, 16 and 24.

Software reaches the block through a plain 32-bit register port, with a write strobe and a combinational read path. Each group has three registers:
- a pending register, where a write of 1 clears a bit;
- a mask-enable register, where a write of 1 sets a mask bit;
- a mask-disable register, where a write of 1 clears a mask bit.

An end-of-interrupt register re-arms a group's line after software has serviced it. Inbound messages arrive on a dedicated capture port, which is the doorbell write already decoded above this block. A register-bus write to the doorbell offset is treated the same way.

Top module: `msi_vec_collector`

## Requirements
- R1: After reset every pending bit and every mask bit reads 0, and every `irq_out` bit is 0.
- R2: A doorbell with data `v` in the range 0 to 31 sets bit `v div 8` of group `v mod 8`. Group `g`'s pending register is at byte offset 0x104 + 0x10·g. Its pending bits are read data bits [3:0], and read data bits [31:4] read 0.
- R3: A doorbell with data 32 or greater changes no pending bit.
- R4: Writing to group `g`'s pending register clears exactly the bits written as 1. All other bits are kept.
- R5: Group `g`'s mask-enable register is at 0x108 + 0x10·g and its mask-disable register is at 0x10C + 0x10·g. A 1 written to either register sets or clears only that mask bit. A read of either register returns the current mask in bits [3:0].
- R6: While group `g` is armed, `irq_out[g]` is 1 exactly when some bit of that group is both pending and unmasked.
- R7: Any write to group `g`'s pending register disarms group `g`. From the next cycle, `irq_out[g]` stays 0 until that group is re-armed.
- R8: A write of the value `g + 4` to the end-of-interrupt register at 0x050 re-arms group `g` only. Any other value re-arms no group.
- R9: If a doorbell sets a bit in the same cycle that a pending-register write clears it, the bit ends up set.
- R10: Messages arrive on the capture port (`msi_valid`, `msi_data`), and a register write to offset 0x054 carries the vector in its write data. The block accepts both as doorbells, and both are captured when they occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msi_valid | input | 1 | Inbound doorbell write strobe |
| msi_data | input | 32 | Inbound doorbell vector number |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq_out | output | 8 | One interrupt line per group |

## Verification
Two cases are hard to reach from the ports.

The first is a doorbell that coincides with a clear of the same bit. The register bus cannot produce it alone, because the bus carries only one write per cycle. The bench therefore drives the capture port and a pending-register write in the same clock cycle.

The second is the disarmed window, where a group has pending, unmasked work but its line stays low. The bench creates it in three steps:
1. It acknowledges a group.
2. It raises a new vector in that group.
3. It writes a wrong end-of-interrupt code.

It then checks that the line stays low until the correct code is written.

// File: rtl/msi_coll_pkg.sv
// Package: register map constants shared by the collector's modules.
// Assumes byte addressing with 32-bit registers.
package msi_coll_pkg;
    localparam int PEND_BASE     = 'h104;
    localparam int MSET_BASE     = 'h108;
    localparam int MCLR_BASE     = 'h10C;
    localparam int GROUP_STRIDE  = 'h010;
    localparam int EOI_OFFSET    = 'h050;
    localparam int DOORBELL_OFS  = 'h054;
    localparam int EOI_CODE_BASE = 4;
endpackage

// File: rtl/msi_db_decode.sv
// Doorbell decoder: turns a vector number into a one-hot set mask.
// The mask is group-major, so group g bit b is index g*BITS+b.
// Vector v selects group v mod GROUPS and bit v div GROUPS.
// Out-of-range numbers produce an all-zero mask.
module msi_db_decode #(
    parameter int GROUPS = 8,
    parameter int BITS   = 4,
    parameter int DATA_W = 32
) (
    input  logic                     valid,
    input  logic [DATA_W-1:0]        data,
    output logic [GROUPS*BITS-1:0]   set_vec
);
    // Compare the data against every vector number.
    always_comb begin
        set_vec = '0;
        for (int g = 0; g < GROUPS; g++) begin
            for (int b = 0; b < BITS; b++) begin
                if (valid && data == DATA_W'(g + GROUPS * b))
                    set_vec[g*BITS+b] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/msi_reg_decode.sv
// Register write decoder: produces per-group strobes from one bus write.
// The strobes cover pending clear, mask set, mask clear and end-of-interrupt.
// It also flags a bus write to the doorbell offset.
// Assumes a single write per cycle.
module msi_reg_decode
    import msi_coll_pkg::*;
#(
    parameter int GROUPS = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [GROUPS-1:0] pend_we,
    output logic [GROUPS-1:0] mset_we,
    output logic [GROUPS-1:0] mclr_we,
    output logic [GROUPS-1:0] eoi_hit,
    output logic              bus_db
);
    genvar g;
    generate
        for (g = 0; g < GROUPS; g++) begin : g_grp
            // Per-group address and EOI-code match.
            always_comb begin
                pend_we[g] = wr && addr == ADDR_W'(PEND_BASE + g * GROUP_STRIDE);
                mset_we[g] = wr && addr == ADDR_W'(MSET_BASE + g * GROUP_STRIDE);
                mclr_we[g] = wr && addr == ADDR_W'(MCLR_BASE + g * GROUP_STRIDE);
                eoi_hit[g] = wr && addr == ADDR_W'(EOI_OFFSET)
                             && wdata == DATA_W'(g + EOI_CODE_BASE);
            end
        end
    endgenerate

    // Bus-side doorbell strobe.
    always_comb bus_db = wr && addr == ADDR_W'(DOORBELL_OFS);
endmodule

// File: rtl/msi_group.sv
// One status group: pending bits, mask bits, arm flag and interrupt line.
// A set from a doorbell wins over a clear in the same cycle.
// Any pending-register write disarms the group, and EOI re-arms it.
module msi_group #(
    parameter int BITS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BITS-1:0] set_bits,
    input  logic            pend_we,
    input  logic            mset_we,
    input  logic            mclr_we,
    input  logic            eoi_hit,
    input  logic [BITS-1:0] wbits,
    output logic [BITS-1:0] pend,
    output logic [BITS-1:0] mask_en,
    output logic            irq
);
    logic armed;

    // Pending bits: clear on write-one, doorbell set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~(pend_we ? wbits : '0)) | set_bits;
    end

    // Mask bits: independent set and clear strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_en <= '0;
        else if (mset_we) mask_en <= mask_en | wbits;
        else if (mclr_we) mask_en <= mask_en & ~wbits;
    end

    // Arm flag: dropped on acknowledge, restored on EOI.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed <= 1'b1;
        else if (eoi_hit) armed <= 1'b1;
        else if (pend_we) armed <= 1'b0;
    end

    // Interrupt line.
    always_comb irq = armed && |(pend & mask_en);

    p_doorbell_sticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        |set_bits |=> (pend & $past(set_bits)) == $past(set_bits));
    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_we && set_bits == '0) |=> (pend & $past(wbits)) == '0);
    p_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mset_we |=> (mask_en & $past(wbits)) == $past(wbits));
    p_mask_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mclr_we |=> (mask_en & $past(wbits)) == '0);
    p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> |(pend & mask_en));
    p_disarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pend_we |=> !irq);
    p_eoi_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_hit && |(pend & mask_en)) |=> irq);
endmodule

// File: rtl/msi_vec_collector.sv
// Top: interleaved MSI vector collector.
// Merges the inbound doorbell and the bus doorbell.
// Builds GROUPS status groups and muxes register reads.
// Assumes one register write per cycle and reads that depend on the address only.
module msi_vec_collector
    import msi_coll_pkg::*;
#(
    parameter int GROUPS = 8,
    parameter int BITS   = 4,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msi_valid,
    input  logic [DATA_W-1:0] msi_data,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [GROUPS-1:0] irq_out
);
    localparam int NVEC = GROUPS * BITS;

    logic [NVEC-1:0]   inb_vec, bus_vec, set_all;
    logic [GROUPS-1:0] pend_we, mset_we, mclr_we, eoi_hit;
    logic              bus_db;
    logic [GROUPS-1:0][BITS-1:0] pend, mask_en;

    msi_reg_decode #(.GROUPS(GROUPS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regdec (
        .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .pend_we(pend_we), .mset_we(mset_we), .mclr_we(mclr_we),
        .eoi_hit(eoi_hit), .bus_db(bus_db)
    );

    msi_db_decode #(.GROUPS(GROUPS), .BITS(BITS), .DATA_W(DATA_W)) u_inb_dec (
        .valid(msi_valid), .data(msi_data), .set_vec(inb_vec)
    );

    msi_db_decode #(.GROUPS(GROUPS), .BITS(BITS), .DATA_W(DATA_W)) u_bus_dec (
        .valid(bus_db), .data(reg_wdata), .set_vec(bus_vec)
    );

    // Both doorbell sources accumulate.
    always_comb set_all = inb_vec | bus_vec;

    genvar g;
    generate
        for (g = 0; g < GROUPS; g++) begin : g_grp
            msi_group #(.BITS(BITS)) u_grp (
                .clk(clk), .rst_n(rst_n),
                .set_bits(set_all[g*BITS +: BITS]),
                .pend_we(pend_we[g]), .mset_we(mset_we[g]), .mclr_we(mclr_we[g]),
                .eoi_hit(eoi_hit[g]), .wbits(reg_wdata[BITS-1:0]),
                .pend(pend[g]), .mask_en(mask_en[g]), .irq(irq_out[g])
            );
        end
    endgenerate

    // Read mux on the byte offset.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < GROUPS; i++) begin
            if (reg_addr == ADDR_W'(PEND_BASE + i * GROUP_STRIDE))
                reg_rdata = DATA_W'(pend[i]);
            if (reg_addr == ADDR_W'(MSET_BASE + i * GROUP_STRIDE) ||
                reg_addr == ADDR_W'(MCLR_BASE + i * GROUP_STRIDE))
                reg_rdata = DATA_W'(mask_en[i]);
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> irq_out == '0);
endmodule

// File: tb/msi_vec_collector_bench.sv
module msi_vec_collector_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msi_valid = 1'b0;
    logic [31:0] msi_data = '0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  irq_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    msi_vec_collector u_msi_vec_collector (
        .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_data(msi_data),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    function automatic logic [11:0] pend_a(int g);
        return 12'(12'h104 + 16 * g);
    endfunction
    function automatic logic [11:0] mset_a(int g);
        return 12'(12'h108 + 16 * g);
    endfunction
    function automatic logic [11:0] mclr_a(int g);
        return 12'(12'h10C + 16 * g);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic ring(logic [31:0] v);
        @(negedge clk);
        msi_valid = 1'b1; msi_data = v;
        @(negedge clk);
        msi_valid = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic clear_all();
        for (int g = 0; g < 8; g++) begin
            bus_wr(pend_a(g), 32'hF);
            bus_wr(mclr_a(g), 32'hF);
            bus_wr(12'h050, 32'(g + 4));
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int g = 0; g < 8; g++) begin
            rd(pend_a(g), d); check("R1 pend", d, 0);
            rd(mset_a(g), d); check("R1 mask", d, 0);
        end
        check("R1 irq", 32'(irq_out), 0);
    endtask

    task automatic t_map();
        logic [31:0] d;
        int vs[4] = '{0, 8, 13, 31};
        foreach (vs[i]) begin
            ring(32'(vs[i]));
            rd(pend_a(vs[i] % 8), d);
            check("R2 map", d, 32'(1) << (vs[i] / 8));
            bus_wr(pend_a(vs[i] % 8), 32'hF);
            rd(pend_a(vs[i] % 8), d);
            check("R4 clear", d, 0);
        end
        bus_wr(12'h050, 32'h0);
        clear_all();
    endtask

    task automatic t_partial_clear();
        logic [31:0] d;
        ring(32'd6); ring(32'd22);
        rd(pend_a(6), d); check("R2 two bits", d, 32'h5);
        bus_wr(pend_a(6), 32'h4);
        rd(pend_a(6), d); check("R4 partial", d, 32'h1);
        clear_all();
    endtask

    task automatic t_ignore();
        logic [31:0] d;
        ring(32'd32); ring(32'hFFFF_FFFF); ring(32'd40);
        for (int g = 0; g < 8; g++) begin
            rd(pend_a(g), d); check("R3 out of range", d, 0);
        end
    endtask

    task automatic t_mask();
        logic [31:0] d;
        bus_wr(mset_a(3), 32'hA);
        bus_wr(mclr_a(3), 32'h2);
        rd(mset_a(3), d); check("R5 set view", d, 32'h8);
        rd(mclr_a(3), d); check("R5 clr view", d, 32'h8);
        rd(mset_a(2), d); check("R5 neighbour", d, 0);
        clear_all();
    endtask

    task automatic t_irq();
        bus_wr(mset_a(2), 32'h2);
        ring(32'd10);
        check("R6 enabled", 32'(irq_out), 32'h04);
        ring(32'd5);
        check("R6 masked", 32'(irq_out), 32'h04);
        bus_wr(mclr_a(2), 32'h2);
        check("R6 mask off", 32'(irq_out), 0);
        clear_all();
    endtask

    task automatic t_eoi();
        bus_wr(mset_a(2), 32'hF);
        ring(32'd2);
        check("R6 line", 32'(irq_out), 32'h04);
        bus_wr(pend_a(2), 32'h1);
        ring(32'd18);
        check("R7 held low", 32'(irq_out), 0);
        bus_wr(12'h050, 32'd7);
        check("R8 wrong code", 32'(irq_out), 0);
        bus_wr(12'h050, 32'd2);
        check("R8 raw index", 32'(irq_out), 0);
        bus_wr(12'h050, 32'd6);
        check("R8 rearm", 32'(irq_out), 32'h04);
        clear_all();
    endtask

    task automatic t_same_cycle();
        logic [31:0] d;
        @(negedge clk);
        msi_valid = 1'b1; msi_data = 32'd4;
        reg_wr = 1'b1; reg_addr = pend_a(4); reg_wdata = 32'h1;
        @(negedge clk);
        msi_valid = 1'b0; reg_wr = 1'b0;
        rd(pend_a(4), d); check("R9 set wins", d, 32'h1);
        clear_all();
    endtask

    task automatic t_bus_db();
        logic [31:0] d;
        bus_wr(12'h054, 32'd17);
        rd(pend_a(1), d); check("R10 bus doorbell", d, 32'h4);
        @(negedge clk);
        msi_valid = 1'b1; msi_data = 32'd3;
        reg_wr = 1'b1; reg_addr = 12'h054; reg_wdata = 32'd27;
        @(negedge clk);
        msi_valid = 1'b0; reg_wr = 1'b0;
        rd(pend_a(3), d); check("R10 both sources", d, 32'h9);
        clear_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_partial_clear();
        t_ignore();
        t_mask();
        t_irq();
        t_eoi();
        t_same_cycle();
        t_bus_db();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule